// File: doc/BRIEF.md
# Hysteretic Step-Down Pulse Controller

This block is the digital core of a bang-bang step-down regulator. A free-running counter divides time into repeating cycles. Each cycle has a charge phase (the up-ramp) followed by a shorter discharge phase (the down-ramp). An external comparator reports when the sensed output has fallen below its reference. The block then closes the power switch for the rest of the current charge phase. If the output stays above the reference for a whole charge phase, no pulse is issued and that cycle is skipped, which is how the regulator idles under light load.

A separate current-limit flag makes the charge-phase counter advance several steps per clock. This ends the phase early and so cuts the maximum on time. Both flags are treated as asynchronous and pass through two-stage synchronizers. The block exports a one-clock marker at the start of each cycle and a saturating count of skipped cycles.

Top module: `buck_pulse_ctrl`

## Requirements
- R1: With the current-limit flag low, a cycle lasts UP_TICKS + UP_TICKS/6 clocks: UP_TICKS clocks of up-ramp (clock indices 0 to UP_TICKS-1), then UP_TICKS/6 clocks of down-ramp. `cycle_start_o` is high for exactly the clock with index 0 of each up-ramp that follows a down-ramp.
- R2: `sw_on_o` is low during every clock of the down-ramp.
- R3: If `fb_low_i` is high during up-ramp clock k, and k+3 is no later than the last up-ramp clock, then `sw_on_o` is high from clock k+3 through the last up-ramp clock.
- R4: Once high, `sw_on_o` stays high until the up-ramp ends, even if `fb_low_i` returns low after a single clock.
- R5: A later fall of the feedback within the up-ramp gives a proportionally shorter pulse: the on time is (last up-ramp index) - 2 - k clocks.
- R6: A cycle in which `sw_on_o` never rises issues no pulse, and `skip_count_o` increases by exactly 1 during that cycle's down-ramp. The count saturates at all ones. A cycle that fires leaves the count unchanged.
- R7: While the synchronized `oc_i` is high, the up-ramp counter advances by OC_STEP per clock. The up-ramp then lasts ceil(UP_TICKS/OC_STEP) clocks, the down-ramp is unchanged, and R3 applies with this shorter up-ramp.
- R8: `rst` is synchronous and active high. While it is applied, `sw_on_o`, `cycle_start_o` and `skip_count_o` are 0. The clock after its release is up-ramp clock 0 without a start marker, so the first `cycle_start_o` comes UP_TICKS + UP_TICKS/6 clocks after release.
- R9: The fastest possible pulse spans up-ramp clocks 3 to the last. With default parameters this is 57 of 70 clocks, below the 6/7 up-ramp share.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_low_i | input | 1 | Output feedback below reference (asynchronous) |
| oc_i | input | 1 | Input current above limit (asynchronous) |
| sw_on_o | output | 1 | Power switch enable |
| cycle_start_o | output | 1 | One-clock marker at the first up-ramp clock |
| skip_count_o | output | SKIP_W | Saturating count of cycles without a pulse |

## Verification
The assertions take the flags as already synchronized. They assume the current-limit flag does not change state so quickly that the counter overshoots its width. That holds because UP_TICKS plus OC_STEP fits the counter by construction. The stimulus changes each flag only at falling clock edges. It holds the current-limit flag steady for a full settling cycle before each measured cycle, so every measured up-ramp runs at a single step size. Feedback is driven either as a held level or as a single-clock pulse, and it is always cleared one cycle before the next measurement.

// File: rtl/buck_pulse_ctrl.sv
module buck_pulse_ctrl #(
  parameter int UP_TICKS = 60,
  parameter int OC_STEP  = 4,
  parameter int SKIP_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fb_low_i,
  input  logic              oc_i,
  output logic              sw_on_o,
  output logic              cycle_start_o,
  output logic [SKIP_W-1:0] skip_count_o
);
  localparam int DN_TICKS = UP_TICKS / 6;
  localparam int CW       = $clog2(UP_TICKS + OC_STEP + 1);

  logic [1:0]    fb_sync, oc_sync;
  logic          up_q, sw_q;
  logic [CW-1:0] cnt_q, step;
  logic          up_end, dn_end;

  assign step    = oc_sync[1] ? CW'(OC_STEP) : CW'(1);
  assign up_end  = up_q && ((cnt_q + step) >= CW'(UP_TICKS));
  assign dn_end  = !up_q && (cnt_q == CW'(DN_TICKS - 1));
  assign sw_on_o = sw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_sync       <= '0;
      oc_sync       <= '0;
      up_q          <= 1'b1;
      cnt_q         <= '0;
      sw_q          <= 1'b0;
      cycle_start_o <= 1'b0;
      skip_count_o  <= '0;
    end else begin
      fb_sync       <= {fb_sync[0], fb_low_i};
      oc_sync       <= {oc_sync[0], oc_i};
      sw_q          <= up_q && !up_end && (sw_q || fb_sync[1]);
      cycle_start_o <= dn_end;
      if (up_q) begin
        if (up_end) begin
          up_q  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + step;
        end
      end else if (dn_end) begin
        up_q  <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (up_end && !sw_q && (skip_count_o != '1))
        skip_count_o <= skip_count_o + 1'b1;
    end
  end
endmodule

module buck_pulse_ctrl_chk #(
  parameter int UP_TICKS = 60,
  parameter int SKIP_W   = 8,
  parameter int CW       = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              sw_on_o,
  input logic              cycle_start_o,
  input logic [SKIP_W-1:0] skip_count_o,
  input logic              up_q,
  input logic [CW-1:0]     cnt_q,
  input logic              fb_s
);
  localparam int DN_TICKS = UP_TICKS / 6;

  assert_sw_only_up_R2: assert property (@(posedge clk) disable iff (rst)
    sw_on_o |-> up_q);

  assert_sw_held_R4: assert property (@(posedge clk) disable iff (rst)
    sw_on_o |=> (sw_on_o || !up_q));

  assert_sw_rise_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_on_o) |-> $past(fb_s));

  assert_start_marks_up0_R1: assert property (@(posedge clk) disable iff (rst)
    cycle_start_o |-> (up_q && cnt_q == '0 && !sw_on_o));

  assert_down_bound_R1: assert property (@(posedge clk) disable iff (rst)
    !up_q |-> (cnt_q < CW'(DN_TICKS)));

  assert_skip_monotone_R6: assert property (@(posedge clk) disable iff (rst)
    !sw_on_o |=> (skip_count_o >= $past(skip_count_o)));

  assert_reset_clears_R8: assert property (@(posedge clk)
    $past(rst) |-> (!sw_on_o && !cycle_start_o && skip_count_o == '0));
endmodule

bind buck_pulse_ctrl buck_pulse_ctrl_chk #(
  .UP_TICKS(UP_TICKS), .SKIP_W(SKIP_W), .CW(CW)
) chk_i (
  .clk(clk), .rst(rst), .sw_on_o(sw_on_o), .cycle_start_o(cycle_start_o),
  .skip_count_o(skip_count_o), .up_q(up_q), .cnt_q(cnt_q), .fb_s(fb_sync[1])
);

// File: tb/buck_pulse_ctrl_test.sv
module buck_pulse_ctrl_test;
  localparam int UP = 60;
  localparam int ST = 4;
  localparam int SW = 8;
  localparam int DN = UP / 6;
  localparam int NV = 9;

  logic clk = 1'b0, rst = 1'b1, fb = 1'b0, oc = 1'b0;
  logic sw_on, cs;
  logic [SW-1:0] skips;
  int checks = 0, fails = 0, ticks = 0;

  always #2.5 clk = ~clk;

  buck_pulse_ctrl #(.UP_TICKS(UP), .OC_STEP(ST), .SKIP_W(SW)) uut (
    .clk(clk), .rst(rst), .fb_low_i(fb), .oc_i(oc),
    .sw_on_o(sw_on), .cycle_start_o(cs), .skip_count_o(skips));

  // each entry: feedback clock index, current-limit flag, single-clock feedback
  localparam int VD [NV] = '{0, 20, 40, 56, 57, 200, 0, 5, 12};
  localparam bit VO [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1};
  localparam bit VP [NV] = '{0, 0, 1, 0, 0, 0, 0, 1, 0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!cs);
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", ticks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 sw in reset", int'(sw_on), 0);
    chk("R8 start in reset", int'(cs), 0);
    chk("R8 skips in reset", int'(skips), 0);
    rst = 1'b0;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!cs);
      chk("R8 first start after release", n, UP + DN);
    end

    for (int v = 0; v < NV; v++) begin
      int nup, exp_on, t, on, dn_on, sk0;
      oc = VO[v];
      fb = 1'b0;
      wait_start();
      wait_start();
      nup = VO[v] ? (UP + ST - 1) / ST : UP;
      exp_on = (VD[v] + 3 <= nup - 1) ? nup - 3 - VD[v] : 0;
      t = 0; on = 0; dn_on = 0; sk0 = int'(skips);
      do begin
        if (sw_on) begin
          on++;
          if (t >= nup) dn_on++;
        end
        if (t == VD[v]) fb = 1'b1;
        if (VP[v] && t == VD[v] + 1) fb = 1'b0;
        t++;
        @(negedge clk);
      end while (!cs);
      if (VO[v]) chk("R7 on clocks under current limit", on, exp_on);
      else if (VP[v]) chk("R4 on clocks after one-clock feedback", on, exp_on);
      else if (VD[v] == 0) chk("R9 widest pulse", on, exp_on);
      else chk("R3 R5 on clocks", on, exp_on);
      chk(VO[v] ? "R7 period" : "R1 period", t, nup + DN);
      chk("R2 sw during down-ramp", dn_on, 0);
      chk("R6 skip increment", int'(skips) - sk0, (exp_on == 0) ? 1 : 0);
    end

    oc = 1'b0;
    fb = 1'b1;
    do @(negedge clk); while (!sw_on);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset drops sw", int'(sw_on), 0);
    chk("R8 reset clears skips", int'(skips), 0);
    rst = 1'b0;
    fb = 1'b0;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!cs);
      chk("R8 restart period", n, UP + DN);
      chk("R6 skip after reset", int'(skips), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule